// File: doc/BRIEF.md
# Packet DMA Transfer Controller

This block paces byte transfers between one selected endpoint buffer and an external DMA master. Software programs a 16-bit configuration word and a 16-bit byte count through a small register port. When the enable bit is set, the block copies the programmed count into a private countdown counter. It then raises a request whenever both the remaining count and the fill level of the endpoint buffer can cover one whole burst. Each acknowledged cycle moves one byte and lowers the counter by one.

A transfer finishes in one of three ways. The counter can reach zero while count-end detection is on. A short or empty packet can arrive on an OUT endpoint while short-packet mode is on. Software can also clear the enable bit. The first two cases pulse the end-of-transfer output. All three drop the request and leave the block disabled.

Two resets are kept apart. Power-on reset clears everything. A bus reset clears only the enable bit and keeps the rest of the setup, so a transfer can be restarted without being programmed again.

Top module: `pkt_dma_ctrl`

## Requirements
- R1: After power-on reset, both registers read 0, and `dma_req` and `dma_eot` are low.
- R2: Configuration layout: bit 15 is count-end enable, bit 14 is short-packet mode, bits 7:4 are the endpoint index (driven on `ep_sel`), bit 3 is DMA enable and bits 1:0 are the burst code. Bits 13:8 and bit 2 ignore writes and read 0. `reg_sel`=0 selects configuration and 1 selects count.
- R3: Burst code 00 gives 1 byte per request, 01 gives 4, 10 gives 8 and 11 gives 16. The request stays high for exactly that many acknowledged cycles and then goes low for at least one cycle.
- R4: A request starts only while enabled, with the remaining count at least the burst size and `buf_level` at least the burst size.
- R5: Every 0-to-1 change of the enable bit reloads the counter from the programmed count. Each cycle with `dma_ack` high while `dma_req` is high lowers it by one. Reading the count register returns the remaining count.
- R6: With count-end enable set, an enabled transfer whose counter is 0 produces a one-cycle `dma_eot` pulse on the next clock. In that same cycle the enable bit is cleared and the request is low.
- R7: With count-end enable clear, reaching a count of 0 gives no `dma_eot`, and the enable bit stays set.
- R8: A `short_pkt` pulse produces `dma_eot` on the next clock and clears enable, but only if the block is enabled, short-packet mode is set and `ep_is_out` is high. Otherwise the pulse is ignored.
- R9: Writing 0 to the enable bit drops the request on the next clock and gives no `dma_eot`. No request follows until the block is enabled again.
- R10: A one-cycle `bus_rst` clears the enable bit and the request. Count-end enable, short-packet mode, endpoint index, burst code and the programmed count keep their values.
- R11: `dma_ack` while `dma_req` is low leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| bus_rst | input | 1 | Synchronous bus reset, clears only enable and request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 configuration, 1 byte count |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| buf_level | input | LVL_W | Bytes the endpoint buffer can move now |
| ep_is_out | input | 1 | Selected endpoint is an OUT endpoint |
| short_pkt | input | 1 | Pulse: short or empty packet received |
| dma_req | output | 1 | Request to the DMA master |
| dma_ack | input | 1 | Acknowledge: one byte moved this cycle |
| dma_eot | output | 1 | One-cycle end-of-transfer pulse |
| ep_sel | output | 4 | Selected endpoint index |

## Verification
The pacing function is tried with every burst code, with counts that are exact multiples of the burst size and with a count that leaves a remainder smaller than one burst. This separates the burst-length decoding from the room check on the count. A buffer level below the burst size, later raised, separates the buffer gate from the count gate. Each way of ending a transfer is tried on its own: count exhaustion with and without count-end detection, short packets on OUT and IN endpoints and while disabled, software clear, and bus reset. Only the expected ones may produce the end pulse. Acknowledges are also given mid-burst and while idle, which separates real byte moves from stray ones in the count readback.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int EP_W  = 4;
    localparam int REG_W = 16;

    // bit positions of the configuration word
    localparam int B_CNT_END = 15;
    localparam int B_SHORT   = 14;
    localparam int B_EP_LO   = 4;
    localparam int B_EN      = 3;
    localparam int B_BL_LO   = 0;

    typedef struct packed {
        logic            cnt_end_en;
        logic            short_en;
        logic [EP_W-1:0] ep_idx;
        logic [1:0]      burst_code;
    } dma_cfg_t;

    function automatic logic [4:0] burst_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/pdma_cfg_regs.sv
module pdma_cfg_regs
    import pdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             bus_rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             stop_i,
    output dma_cfg_t         cfg_o,
    output logic             en_o,
    output logic             en_next_o,
    output logic             load_o,
    output logic [CNT_W-1:0] prog_o
);

    typedef struct packed {
        dma_cfg_t         cfg;
        logic             en;
        logic [CNT_W-1:0] prog;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  load_d;

    always_comb begin
        regs_d = regs_q;
        load_d = 1'b0;
        if (wr_en && !wr_sel) begin
            regs_d.cfg.cnt_end_en = wr_data[B_CNT_END];
            regs_d.cfg.short_en   = wr_data[B_SHORT];
            regs_d.cfg.ep_idx     = wr_data[B_EP_LO +: EP_W];
            regs_d.cfg.burst_code = wr_data[B_BL_LO +: 2];
            regs_d.en             = wr_data[B_EN];
            load_d                = wr_data[B_EN] && !regs_q.en;
        end
        if (wr_en && wr_sel) begin
            regs_d.prog = wr_data[CNT_W-1:0];
        end
        if (stop_i) begin
            regs_d.en = 1'b0;
            load_d    = 1'b0;
        end
        if (bus_rst) begin
            regs_d    = regs_q;
            regs_d.en = 1'b0;
            load_d    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cfg_o     = regs_q.cfg;
    assign en_o      = regs_q.en;
    assign en_next_o = regs_d.en;
    assign load_o    = load_d;
    assign prog_o    = regs_q.prog;

    // R10: bus reset keeps setup, clears enable
    p_bus_reset_keeps_r10: assert property (@(posedge clk) disable iff (!por_n)
        bus_rst |=> (!en_o && cfg_o == $past(cfg_o) && prog_o == $past(prog_o)));

endmodule

// File: rtl/pdma_counter.sv
module pdma_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] remain_o
);

    logic [CNT_W-1:0] remain_d, remain_q;

    always_comb begin
        remain_d = remain_q;
        if (load_i)
            remain_d = load_val_i;
        else if (dec_i && remain_q != '0)
            remain_d = remain_q - 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) remain_q <= '0;
        else        remain_q <= remain_d;
    end

    assign remain_o = remain_q;

    // R5: a load takes the programmed value
    p_load_value_r5: assert property (@(posedge clk) disable iff (!por_n)
        load_i |=> remain_o == $past(load_val_i));

endmodule

// File: rtl/pdma_burst.sv
module pdma_burst
    import pdma_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run_i,
    input  logic [1:0]       code_i,
    input  logic [CNT_W-1:0] remain_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             ack_i,
    output logic             req_o
);

    typedef struct packed {
        logic       req;
        logic [4:0] beats;
    } pace_t;

    pace_t      pace_d, pace_q;
    logic [4:0] blen;
    logic       room_ok;

    always_comb begin
        blen    = burst_bytes(code_i);
        room_ok = (remain_i >= CNT_W'(blen)) && (level_i >= LVL_W'(blen));
        pace_d  = pace_q;
        if (!run_i) begin
            pace_d = '0;
        end else if (pace_q.req) begin
            if (ack_i) begin
                if (pace_q.beats == 5'd1) pace_d = '0;
                else                      pace_d.beats = pace_q.beats - 5'd1;
            end
        end else if (room_ok) begin
            pace_d.req   = 1'b1;
            pace_d.beats = blen;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pace_q <= '0;
        else        pace_q <= pace_d;
    end

    assign req_o = pace_q.req;

    // R3: an active request always has beats left, never more than 16
    p_beats_bound_r3: assert property (@(posedge clk) disable iff (!por_n)
        pace_q.req |-> (pace_q.beats != 5'd0 && pace_q.beats <= 5'd16));

    // R4: a request starts only with room in count and buffer
    p_start_room_r4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(req_o) |-> ($past(level_i) >= LVL_W'(burst_bytes($past(code_i)))
                          && $past(remain_i) >= CNT_W'(burst_bytes($past(code_i)))));

endmodule

// File: rtl/pkt_dma_ctrl.sv
module pkt_dma_ctrl
    import pdma_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             bus_rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [LVL_W-1:0] buf_level,
    input  logic             ep_is_out,
    input  logic             short_pkt,
    output logic             dma_req,
    input  logic             dma_ack,
    output logic             dma_eot,
    output logic [3:0]       ep_sel
);

    dma_cfg_t         cfg;
    logic             en_q, en_next, load;
    logic [CNT_W-1:0] prog, remain;
    logic             eot_cond, eot_d, eot_q;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[13:8], reg_wdata[2]};

    pdma_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .bus_rst   (bus_rst),
        .wr_en     (reg_wr),
        .wr_sel    (reg_sel),
        .wr_data   (reg_wdata),
        .stop_i    (eot_cond),
        .cfg_o     (cfg),
        .en_o      (en_q),
        .en_next_o (en_next),
        .load_o    (load),
        .prog_o    (prog)
    );

    pdma_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .por_n      (por_n),
        .load_i     (load),
        .load_val_i (prog),
        .dec_i      (dma_ack && dma_req),
        .remain_o   (remain)
    );

    pdma_burst #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_pace (
        .clk      (clk),
        .por_n    (por_n),
        .run_i    (en_q && en_next),
        .code_i   (cfg.burst_code),
        .remain_i (remain),
        .level_i  (buf_level),
        .ack_i    (dma_ack),
        .req_o    (dma_req)
    );

    always_comb begin
        eot_cond = en_q && ((cfg.cnt_end_en && remain == '0) ||
                            (cfg.short_en && ep_is_out && short_pkt));
        eot_d    = eot_cond && !bus_rst;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) eot_q <= 1'b0;
        else        eot_q <= eot_d;
    end

    assign dma_eot = eot_q;
    assign ep_sel  = cfg.ep_idx;

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata = 16'(remain);
        end else begin
            reg_rdata[B_CNT_END]       = cfg.cnt_end_en;
            reg_rdata[B_SHORT]         = cfg.short_en;
            reg_rdata[B_EP_LO +: EP_W] = cfg.ep_idx;
            reg_rdata[B_EN]            = en_q;
            reg_rdata[B_BL_LO +: 2]    = cfg.burst_code;
        end
    end

    // R6: end pulse lasts one cycle
    p_eot_single_r6: assert property (@(posedge clk) disable iff (!por_n)
        dma_eot |=> !dma_eot);
    // R6: end pulse comes with request low and enable clear
    p_eot_quiet_r6: assert property (@(posedge clk) disable iff (!por_n)
        dma_eot |-> (!dma_req && !en_q));
    // R9: no request while disabled
    p_req_needs_en_r9: assert property (@(posedge clk) disable iff (!por_n)
        dma_req |-> en_q);
    // R5: an acknowledged byte lowers the count by one
    p_ack_counts_r5: assert property (@(posedge clk) disable iff (!por_n)
        (dma_ack && dma_req && remain != '0) |=> remain == $past(remain) - 1'b1);
    // R11: no request, no change of count while enabled
    p_idle_ack_r11: assert property (@(posedge clk) disable iff (!por_n)
        (en_q && !dma_req) |=> $stable(remain));
    // R8: no end pulse out of a disabled state
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!por_n)
        !en_q |=> !dma_eot);

endmodule

// File: tb/pkt_dma_ctrl_tb.sv
module pkt_dma_ctrl_tb;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  buf_level = 8'd16;
    logic        ep_is_out = 1'b1;
    logic        short_pkt = 1'b0;
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic        dma_eot;
    logic [3:0]  ep_sel;

    int errors = 0;
    int checks = 0;
    int eot_seen = 0;
    int run_len = 0;
    int cycles = 0;
    logic ack_on = 1'b0;
    logic stray = 1'b0;
    int exp_q[$];

    always #4 clk = ~clk;

    pkt_dma_ctrl u_dut (
        .clk(clk), .por_n(por_n), .bus_rst(bus_rst), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_level(buf_level), .ep_is_out(ep_is_out), .short_pkt(short_pkt),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_eot(dma_eot), .ep_sel(ep_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: stub DMA master and burst scoreboard
    always @(negedge clk) begin
        if (dma_eot) eot_seen++;
        if (ack_on && dma_req) begin
            run_len++;
        end else if (!dma_req && run_len > 0) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected burst", run_len, 0);
            end else begin
                chk("R3 burst length", run_len, exp_q.pop_front());
            end
            run_len = 0;
        end
        dma_ack <= (ack_on && dma_req) || stray;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic s, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [15:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic expect_burst(input int n);
        exp_q.push_back(n);
    endtask

    task automatic drain();
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R3 all bursts seen", exp_q.size(), 0);
    endtask

    initial begin
        logic [15:0] v;
        int e0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1
        rd(1'b0, v); chk("R1 cfg after por", v, 16'h0000);
        rd(1'b1, v); chk("R1 count after por", v, 16'h0000);
        chk("R1 req after por", dma_req, 1'b0);
        chk("R1 eot after por", dma_eot, 1'b0);

        // R2 reserved bits
        wr(1'b0, 16'h3F04);
        rd(1'b0, v); chk("R2 reserved bits", v, 16'h0000);

        // R3 R6: burst 4, count 8, count-end on, endpoint 5
        ack_on = 1'b1;
        wr(1'b1, 16'd8);
        e0 = eot_seen;
        expect_burst(4); expect_burst(4);
        wr(1'b0, 16'h8059);
        chk("R2 ep_sel", ep_sel, 4'h5);
        drain();
        chk("R6 one eot", eot_seen, e0 + 1);
        rd(1'b0, v); chk("R6 enable cleared", v, 16'h8051);
        rd(1'b1, v); chk("R5 count zero", v, 16'h0000);

        // R3 single-cycle mode
        wr(1'b1, 16'd3);
        e0 = eot_seen;
        expect_burst(1); expect_burst(1); expect_burst(1);
        wr(1'b0, 16'h8008);
        drain();
        chk("R6 eot single mode", eot_seen, e0 + 1);

        // R3 burst 16
        wr(1'b1, 16'd16);
        e0 = eot_seen;
        expect_burst(16);
        wr(1'b0, 16'h800B);
        drain();
        chk("R6 eot burst16", eot_seen, e0 + 1);

        // R7 burst 8, count-end off
        wr(1'b1, 16'd8);
        e0 = eot_seen;
        expect_burst(8);
        wr(1'b0, 16'h000A);
        drain();
        repeat (10) @(negedge clk);
        chk("R7 no eot", eot_seen, e0);
        rd(1'b0, v); chk("R7 still enabled", v, 16'h000A);
        rd(1'b1, v); chk("R7 count zero", v, 16'h0000);
        wr(1'b0, 16'h0000);

        // R4 remainder smaller than a burst
        wr(1'b1, 16'd6);
        expect_burst(4);
        wr(1'b0, 16'h0009);
        drain();
        repeat (20) @(negedge clk);
        chk("R4 no request on remainder", dma_req, 1'b0);
        rd(1'b1, v); chk("R4 remainder count", v, 16'd2);
        wr(1'b0, 16'h0000);

        // R4 buffer level gate
        buf_level = 8'd3;
        wr(1'b1, 16'd8);
        wr(1'b0, 16'h0009);
        repeat (20) @(negedge clk);
        chk("R4 no request low level", dma_req, 1'b0);
        rd(1'b1, v); chk("R4 count untouched", v, 16'd8);
        buf_level = 8'd16;
        expect_burst(4); expect_burst(4);
        drain();
        rd(1'b1, v); chk("R4 count after level", v, 16'd0);
        wr(1'b0, 16'h0000);
        ack_on = 1'b0;

        // R8 short packet on OUT endpoint
        ep_is_out = 1'b1;
        wr(1'b1, 16'd100);
        wr(1'b0, 16'h4008);
        repeat (2) @(negedge clk);
        chk("R8 request up", dma_req, 1'b1);
        short_pkt = 1'b1;
        @(negedge clk);
        short_pkt = 1'b0;
        chk("R8 eot on short", dma_eot, 1'b1);
        chk("R8 req dropped", dma_req, 1'b0);
        @(negedge clk);
        chk("R8 eot one cycle", dma_eot, 1'b0);
        rd(1'b0, v); chk("R8 enable cleared", v, 16'h4000);

        // R8 short while disabled
        e0 = eot_seen;
        short_pkt = 1'b1;
        @(negedge clk);
        short_pkt = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 ignored when disabled", eot_seen, e0);

        // R8 short on IN endpoint
        ep_is_out = 1'b0;
        wr(1'b0, 16'h4008);
        repeat (2) @(negedge clk);
        short_pkt = 1'b1;
        @(negedge clk);
        short_pkt = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 ignored on IN", eot_seen, e0);
        rd(1'b0, v); chk("R8 IN stays enabled", v, 16'h4008);
        chk("R9 request before stop", dma_req, 1'b1);

        // R9 software stop
        wr(1'b0, 16'h4000);
        chk("R9 request dropped", dma_req, 1'b0);
        repeat (6) @(negedge clk);
        chk("R9 no eot on stop", eot_seen, e0);
        chk("R9 stays idle", dma_req, 1'b0);
        ep_is_out = 1'b1;

        // R5 R10: mid-burst acks, then bus reset
        wr(1'b1, 16'h1234);
        wr(1'b0, 16'h80AA);
        repeat (2) @(negedge clk);
        chk("R10 request up", dma_req, 1'b1);
        @(posedge clk); #1 stray = 1'b1;
        repeat (3) @(negedge clk);
        #1 stray = 1'b0;
        repeat (2) @(negedge clk);
        rd(1'b1, v); chk("R5 count after three acks", v, 16'h1231);
        e0 = eot_seen;
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        chk("R10 request cleared", dma_req, 1'b0);
        rd(1'b0, v); chk("R10 setup kept", v, 16'h80A2);
        chk("R10 ep_sel kept", ep_sel, 4'hA);
        repeat (3) @(negedge clk);
        chk("R10 no eot", eot_seen, e0);
        wr(1'b0, 16'h80AA);
        rd(1'b1, v); chk("R10 R5 reload from kept count", v, 16'h1234);
        wr(1'b0, 16'h80A2);

        // R11 stray acknowledge while idle
        buf_level = 8'd0;
        wr(1'b1, 16'd5);
        wr(1'b0, 16'h0008);
        @(posedge clk); #1 stray = 1'b1;
        repeat (3) @(negedge clk);
        #1 stray = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 request low", dma_req, 1'b0);
        rd(1'b1, v); chk("R11 count unchanged", v, 16'd5);
        wr(1'b0, 16'h0000);

        chk("R3 queue empty at end", exp_q.size(), 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule